// File: doc/BRIEF.md
# Adaptive On-Time Buck Gate Sequencer

This block is the digital timing core of one channel of a synchronous step-down converter. It has no oscillator. A switching cycle starts only when the feedback comparator reports that the output has fallen below its target. The block then drives the high-side gate for a one-shot interval. That interval is computed from an output-voltage code and an input-voltage code, so the switching frequency stays nearly constant across input voltages.

After the high-side pulse, the block waits a dead time with both gates off and then turns on the low-side gate. The low-side stays on until one of two things happens. Either the inductor current reaches zero, which gives discontinuous operation at light load, or a new demand arrives once the minimum off-time has elapsed. A valley over-current flag holds the low-side on and delays the next cycle until the current drops back under the limit. A demand that arrives during the minimum off-time is latched and is served as soon as that off-time expires.

The analog comparators, the gate drivers and the ripple-injection ramp live outside this block. They reach it as single-bit, clock-synchronous flags.

Top module: `aot_gate_seq`

## Requirements
- R1: The high-side pulse lasts exactly N cycles, where N = (K_SCALE * vout_code_i) / vin_code_i using integer division. A result of 0 becomes 1. A result above 2^CNT_W - 1 becomes 2^CNT_W - 1, and so does vin_code_i = 0.
- R2: The high-side turns on only when there is a demand, meaning fb_low_i = 1 (feedback below reference) or a latched request. With no demand, both gates stay off indefinitely.
- R3: The high-side pulse width depends only on the voltage codes, never on the load mode. A discontinuous-mode pulse and a continuous-mode pulse with the same codes have the same width.
- R4: After the high-side turns off, at least MIN_OFF_CYC cycles pass before it turns on again. If demand is held continuously and no flags intervene, the high-side is off for exactly MIN_OFF_CYC + DEAD_CYC cycles and the low-side is on for MIN_OFF_CYC - DEAD_CYC cycles.
- R5: Both gates are off for exactly DEAD_CYC cycles between a high-side fall and the next low-side rise, and for at least DEAD_CYC cycles between a low-side fall and the next high-side rise. In the normal sequence that second gap is exactly DEAD_CYC.
- R6: When zero_cross_i = 1 (inductor current at zero) is seen while the low-side is on, the low-side turns off on the next cycle. Both gates then stay off until the next demand.
- R7: While the low-side is on and valley_oc_i = 1, the low-side stays on and no new cycle starts. After the flag clears, the low-side falls on the next cycle, provided demand exists and the off-time has elapsed.
- R8: A demand pulse that arrives during the minimum off-time is remembered even after fb_low_i drops. The high-side then turns on exactly MIN_OFF_CYC cycles after its previous fall.
- R9: While en_i = 0, both gate outputs are 0 in that same cycle and every timer and the latched request are cleared. After en_i returns to 1 with demand present, the high-side rises at the first clock edge, with no off-time wait.
- R10: The two gate outputs are never 1 at the same time.
- R11: During and right after reset, both gate outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable; 0 forces both gates off and clears the timers |
| fb_low_i | input | 1 | 1 when feedback is below reference (demand) |
| zero_cross_i | input | 1 | 1 when inductor current has reached zero |
| valley_oc_i | input | 1 | 1 when sensed valley current exceeds the limit |
| vout_code_i | input | CODE_W | Output-voltage code |
| vin_code_i | input | CODE_W | Input-voltage code |
| hs_gate_o | output | 1 | High-side gate enable |
| ls_gate_o | output | 1 | Low-side gate enable |

## Verification
A corrupted phase counter or state register shows up at the gate ports within one switching cycle. It appears as a wrong high-side width, a dead gap of the wrong length, or a gate stuck on. The bench measures every pulse width and every gap at the ports and compares each against the value derived from the requirements. A lost or spurious pending request shifts the next high-side rise away from the exact off-time boundary, or produces a pulse while the bench expects silence. A stuck off-time counter either lets the high-side rise too early, which the checker flags on that very rising edge, or prevents the high-side from rising at all.

// File: rtl/aot_pkg.sv
`timescale 1ns/1ps
package aot_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_HS      = 3'd1,
        ST_DEAD_HL = 3'd2,
        ST_LS      = 3'd3,
        ST_DEAD_LH = 3'd4
    } seq_state_t;

    typedef struct packed {
        seq_state_t state;
        logic       pend;
    } seq_regs_t;

endpackage

// File: rtl/aot_countdown.sv
`timescale 1ns/1ps
// Loadable down-counter that stops at zero; clear has priority over load.
module aot_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr_i) begin
            cnt_d = '0;
        end else if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/aot_ontime_calc.sv
`timescale 1ns/1ps
// Registered one-shot length: K*vout/vin, clamped to [1, 2^CNT_W-1].
module aot_ontime_calc #(
    parameter int CODE_W  = 8,
    parameter int CNT_W   = 10,
    parameter int K_SCALE = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] vout_i,
    input  logic [CODE_W-1:0] vin_i,
    output logic [CNT_W-1:0]  on_cycles_o
);
    localparam int K_W    = $clog2(K_SCALE + 1);
    localparam int PROD_W = CODE_W + K_W;
    localparam int DIV_W  = (PROD_W > CNT_W) ? PROD_W : CNT_W;
    localparam logic [CNT_W-1:0] ON_MAX = '1;
    localparam logic [DIV_W-1:0] K_EXT  = DIV_W'(K_SCALE);
    localparam logic [DIV_W-1:0] MAX_EXT = DIV_W'(ON_MAX);

    logic [DIV_W-1:0] prod, divisor, quo;
    logic [CNT_W-1:0] on_d, on_q;

    always_comb begin
        prod    = K_EXT * DIV_W'(vout_i);
        divisor = (vin_i == '0) ? DIV_W'(1) : DIV_W'(vin_i);
        quo     = prod / divisor;
        if (vin_i == '0) begin
            on_d = ON_MAX;
        end else if (quo == '0) begin
            on_d = CNT_W'(1);
        end else if (quo > MAX_EXT) begin
            on_d = ON_MAX;
        end else begin
            on_d = CNT_W'(quo);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_q <= CNT_W'(1);
        end else begin
            on_q <= on_d;
        end
    end

    assign on_cycles_o = on_q;
endmodule

// File: rtl/aot_gate_seq.sv
`timescale 1ns/1ps
module aot_gate_seq
    import aot_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int CNT_W       = 10,
    parameter int K_SCALE     = 32,
    parameter int DEAD_CYC    = 8,
    parameter int MIN_OFF_CYC = 43
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              fb_low_i,
    input  logic              zero_cross_i,
    input  logic              valley_oc_i,
    input  logic [CODE_W-1:0] vout_code_i,
    input  logic [CODE_W-1:0] vin_code_i,
    output logic              hs_gate_o,
    output logic              ls_gate_o
);
    localparam int OFF_W = $clog2(MIN_OFF_CYC + 1);
    localparam logic [CNT_W-1:0] DEAD_LD = CNT_W'(DEAD_CYC);
    localparam logic [CNT_W-1:0] PH_LAST = CNT_W'(1);
    localparam logic [OFF_W-1:0] OFF_LD  = OFF_W'(MIN_OFF_CYC - 1);

    seq_regs_t        cur_q, nxt_d;
    logic [CNT_W-1:0] on_cycles;
    logic [CNT_W-1:0] ph_cnt, ph_val;
    logic [OFF_W-1:0] off_cnt;
    logic             ph_load, off_load, tmr_clr;
    logic             req, ph_last, off_done, start_hs;

    aot_ontime_calc #(
        .CODE_W (CODE_W),
        .CNT_W  (CNT_W),
        .K_SCALE(K_SCALE)
    ) ontime_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .vout_i     (vout_code_i),
        .vin_i      (vin_code_i),
        .on_cycles_o(on_cycles)
    );

    // Phase timer: high-side one-shot and both dead windows.
    aot_countdown #(.W(CNT_W)) phase_tmr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (tmr_clr),
        .load_i    (ph_load),
        .load_val_i(ph_val),
        .cnt_o     (ph_cnt)
    );

    // Minimum off-time, started when the high-side turns off.
    aot_countdown #(.W(OFF_W)) off_tmr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (tmr_clr),
        .load_i    (off_load),
        .load_val_i(OFF_LD),
        .cnt_o     (off_cnt)
    );

    assign req      = fb_low_i | cur_q.pend;
    assign ph_last  = (ph_cnt == PH_LAST);
    assign off_done = (off_cnt == '0);
    assign tmr_clr  = ~en_i;

    always_comb begin
        nxt_d    = cur_q;
        ph_load  = 1'b0;
        ph_val   = DEAD_LD;
        off_load = 1'b0;
        start_hs = 1'b0;

        unique case (cur_q.state)
            ST_IDLE: begin
                if (req && off_done) begin
                    start_hs = 1'b1;
                end
            end
            ST_HS: begin
                if (ph_last) begin
                    nxt_d.state = ST_DEAD_HL;
                    ph_load     = 1'b1;
                    off_load    = 1'b1;
                end
            end
            ST_DEAD_HL: begin
                if (ph_last) begin
                    nxt_d.state = ST_LS;
                end
            end
            ST_LS: begin
                if (zero_cross_i || (req && off_done && !valley_oc_i)) begin
                    nxt_d.state = ST_DEAD_LH;
                    ph_load     = 1'b1;
                end
            end
            ST_DEAD_LH: begin
                if (ph_last) begin
                    if (req && off_done) begin
                        start_hs = 1'b1;
                    end else begin
                        nxt_d.state = ST_IDLE;
                    end
                end
            end
            default: nxt_d.state = ST_IDLE;
        endcase

        if (start_hs) begin
            nxt_d.state = ST_HS;
            nxt_d.pend  = 1'b0;
            ph_load     = 1'b1;
            ph_val      = on_cycles;
        end else if (fb_low_i && cur_q.state != ST_HS) begin
            nxt_d.pend = 1'b1;
        end

        if (!en_i) begin
            nxt_d.state = ST_IDLE;
            nxt_d.pend  = 1'b0;
            ph_load     = 1'b0;
            off_load    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state <= ST_IDLE;
            cur_q.pend  <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign hs_gate_o = en_i && (cur_q.state == ST_HS);
    assign ls_gate_o = en_i && (cur_q.state == ST_LS);
endmodule

// File: rtl/aot_gate_seq_chk.sv
`timescale 1ns/1ps
module aot_gate_seq_chk #(
    parameter int DEAD_CYC    = 8,
    parameter int MIN_OFF_CYC = 43
) (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic zero_cross_i,
    input logic valley_oc_i,
    input logic hs_gate_o,
    input logic ls_gate_o
);
    localparam int HC_W = $clog2(MIN_OFF_CYC + 1);
    localparam int LC_W = $clog2(DEAD_CYC + 1);
    localparam logic [HC_W-1:0] HC_SAT  = HC_W'(MIN_OFF_CYC);
    localparam logic [HC_W-1:0] HC_DEAD = HC_W'(DEAD_CYC);
    localparam logic [LC_W-1:0] LC_SAT  = LC_W'(DEAD_CYC);

    logic [HC_W-1:0] hs_low_cnt;
    logic [LC_W-1:0] ls_low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_low_cnt <= HC_SAT;
            ls_low_cnt <= LC_SAT;
        end else if (!en_i) begin
            hs_low_cnt <= HC_SAT;
            ls_low_cnt <= LC_SAT;
        end else begin
            if (hs_gate_o)                hs_low_cnt <= '0;
            else if (hs_low_cnt != HC_SAT) hs_low_cnt <= hs_low_cnt + 1'b1;
            if (ls_gate_o)                ls_low_cnt <= '0;
            else if (ls_low_cnt != LC_SAT) ls_low_cnt <= ls_low_cnt + 1'b1;
        end
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate_o && ls_gate_o)); // R10
    AST_EN_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (!hs_gate_o && !ls_gate_o)); // R9
    AST_MIN_OFF_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate_o) |-> (hs_low_cnt >= HC_SAT)); // R4
    AST_DEAD_HS_TO_LS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate_o) |-> (hs_low_cnt >= HC_DEAD)); // R5
    AST_DEAD_LS_TO_HS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate_o) |-> (ls_low_cnt >= LC_SAT)); // R5
    AST_ZC_CUTS_LS: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_gate_o && zero_cross_i) |=> !ls_gate_o); // R6
    AST_OC_HOLDS_LS: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_gate_o && valley_oc_i && !zero_cross_i) |=> (ls_gate_o || !en_i)); // R7
endmodule

bind aot_gate_seq aot_gate_seq_chk #(
    .DEAD_CYC   (DEAD_CYC),
    .MIN_OFF_CYC(MIN_OFF_CYC)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .zero_cross_i(zero_cross_i),
    .valley_oc_i (valley_oc_i),
    .hs_gate_o   (hs_gate_o),
    .ls_gate_o   (ls_gate_o)
);

// File: tb/aot_gate_seq_tb_top.sv
`timescale 1ns/1ps
module aot_gate_seq_tb_top;
    localparam int CODE_W  = 8;
    localparam int CNT_W   = 10;
    localparam int K_SCALE = 32;
    localparam int DEAD    = 8;
    localparam int MIN_OFF = 43;
    localparam int ON_MAX  = (1 << CNT_W) - 1;

    localparam int EV_HS_W  = 0;
    localparam int EV_LS_W  = 1;
    localparam int EV_DT_HL = 2;
    localparam int EV_DT_LH = 3;
    localparam int EV_GAP   = 4;

    typedef struct {
        int    kind;
        int    val;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n, en, fb_low, zc, oc;
    logic [CODE_W-1:0] vout, vin;
    logic hs, ls;

    exp_t expq[$];
    int n_tests = 0;
    int n_fail  = 0;
    int hs_rises = 0;
    int ls_rises = 0;
    int overlap  = 0;

    always #2.5 clk = ~clk;

    aot_gate_seq #(
        .CODE_W(CODE_W), .CNT_W(CNT_W), .K_SCALE(K_SCALE),
        .DEAD_CYC(DEAD), .MIN_OFF_CYC(MIN_OFF)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en), .fb_low_i(fb_low),
        .zero_cross_i(zc), .valley_oc_i(oc),
        .vout_code_i(vout), .vin_code_i(vin),
        .hs_gate_o(hs), .ls_gate_o(ls)
    );

    function automatic void check(bit ok, string tag, int act, int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endfunction

    function automatic void push(int kind, int val, string tag);
        exp_t e;
        e.kind = kind; e.val = val; e.tag = tag;
        expq.push_back(e);
    endfunction

    function automatic void observe(int kind, int val);
        exp_t e;
        if (expq.size() != 0 && expq[0].kind == kind) begin
            e = expq.pop_front();
            check(val == e.val, e.tag, val, e.val);
        end
    endfunction

    function automatic int ontime(int vo, int vi);
        int q;
        if (vi == 0) return ON_MAX;
        q = (K_SCALE * vo) / vi;
        if (q == 0) return 1;
        if (q > ON_MAX) return ON_MAX;
        return q;
    endfunction

    // Monitor: one sample per cycle, 1 ns after the rising edge.
    initial begin
        int  hs_hi, hs_lo, ls_hi, ls_lo;
        logic p_hs, p_ls;
        hs_hi = 0; hs_lo = 0; ls_hi = 0; ls_lo = 0;
        p_hs = 1'b0; p_ls = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            if (rst_n !== 1'b1) begin
                hs_hi = 0; hs_lo = 1000; ls_hi = 0; ls_lo = 1000;
                p_hs = 1'b0; p_ls = 1'b0;
            end else begin
                if (hs && ls) overlap++;
                if (p_hs && !hs) observe(EV_HS_W, hs_hi);
                if (p_ls && !ls) observe(EV_LS_W, ls_hi);
                if (!p_ls && ls) begin
                    observe(EV_DT_HL, hs_lo);
                    ls_rises++;
                end
                if (!p_hs && hs) begin
                    observe(EV_DT_LH, ls_lo);
                    observe(EV_GAP, hs_lo);
                    hs_rises++;
                end
                if (hs) hs_hi = p_hs ? hs_hi + 1 : 1;
                else    hs_lo = p_hs ? 1 : hs_lo + 1;
                if (ls) ls_hi = p_ls ? ls_hi + 1 : 1;
                else    ls_lo = p_ls ? 1 : ls_lo + 1;
                p_hs = hs; p_ls = ls;
            end
        end
    end

    task automatic drain();
        while (expq.size() != 0) @(negedge clk);
    endtask

    task automatic settle();
        fb_low = 1'b0; oc = 1'b0; zc = 1'b1;
        repeat (150) @(negedge clk);
        zc = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic pulse_fb();
        fb_low = 1'b1;
        @(negedge clk);
        fb_low = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int h0, l0, n12;
        rst_n = 1'b0; en = 1'b0; fb_low = 1'b0; zc = 1'b0; oc = 1'b0;
        vout = 8'd45; vin = 8'd120;
        n12 = ontime(45, 120);
        repeat (5) @(negedge clk);
        check(hs == 1'b0, "R11 hs in reset", hs, 0);
        check(ls == 1'b0, "R11 ls in reset", ls, 0);
        rst_n = 1'b1; en = 1'b1;
        repeat (5) @(negedge clk);

        // Continuous conduction: demand held high.
        push(EV_HS_W,  n12,             "R1 hs width 45/120");
        push(EV_DT_HL, DEAD,            "R5 dead hs->ls");
        push(EV_LS_W,  MIN_OFF - DEAD,  "R4 ls width ccm");
        push(EV_DT_LH, DEAD,            "R5 dead ls->hs");
        push(EV_GAP,   MIN_OFF + DEAD,  "R4 hs off gap ccm");
        push(EV_HS_W,  n12,             "R1 second hs width");
        fb_low = 1'b1;
        drain();
        settle();

        // Discontinuous: single demand, zero-cross ends low-side.
        vout = 8'd90;
        repeat (3) @(negedge clk);
        push(EV_HS_W,  ontime(90, 120), "R1 hs width 90/120");
        push(EV_DT_HL, DEAD,            "R5 dead hs->ls dcm");
        push(EV_LS_W,  10,              "R6 ls cut by zero-cross");
        pulse_fb();
        @(posedge ls);
        repeat (10) @(negedge clk);
        zc = 1'b1;
        @(negedge clk);
        zc = 1'b0;
        drain();
        h0 = hs_rises; l0 = ls_rises;
        repeat (200) @(negedge clk);
        check(hs_rises == h0, "R2 no hs without demand", hs_rises - h0, 0);
        check(ls_rises == l0, "R6 ls stays off after zero-cross", ls_rises - l0, 0);

        // Pending demand during off-time, same codes as the CCM run.
        vout = 8'd45;
        repeat (3) @(negedge clk);
        zc = 1'b1;
        push(EV_HS_W,  n12,     "R3 dcm hs width equals ccm");
        push(EV_DT_HL, DEAD,    "R5 dead before short ls");
        push(EV_LS_W,  1,       "R6 ls one cycle with zc set");
        push(EV_GAP,   MIN_OFF, "R8 pending served at off-time end");
        push(EV_HS_W,  n12,     "R3 pending pulse width");
        pulse_fb();
        @(negedge ls);
        repeat (5) @(negedge clk);
        pulse_fb();
        drain();
        settle();

        // Valley over-current holds the low-side.
        push(EV_HS_W,  n12,  "R1 hs width before oc");
        push(EV_DT_HL, DEAD, "R5 dead before oc ls");
        push(EV_LS_W,  60,   "R7 ls held by valley oc");
        push(EV_DT_LH, DEAD, "R7 dead after oc clears");
        push(EV_HS_W,  n12,  "R1 hs width after oc");
        oc = 1'b1; fb_low = 1'b1;
        @(posedge ls);
        repeat (60) @(negedge clk);
        oc = 1'b0;
        drain();
        settle();

        // Clamp cases.
        vout = 8'd1; vin = 8'd200;
        repeat (3) @(negedge clk);
        push(EV_HS_W, 1, "R1 clamp to one cycle");
        pulse_fb();
        drain();
        settle();
        vout = 8'd45; vin = 8'd0;
        repeat (3) @(negedge clk);
        push(EV_HS_W, ON_MAX, "R1 zero vin gives max");
        pulse_fb();
        drain();
        settle();

        // Enable drop mid-pulse, then restart.
        vin = 8'd120;
        repeat (3) @(negedge clk);
        fb_low = 1'b1;
        @(posedge hs);
        repeat (4) @(negedge clk);
        en = 1'b0;
        #1;
        check(!hs && !ls, "R9 gates off with en low", {hs, ls}, 0);
        repeat (5) @(negedge clk);
        check(!hs && !ls, "R9 gates stay off", {hs, ls}, 0);
        push(EV_HS_W, n12, "R9 full pulse after re-enable");
        en = 1'b1;
        @(posedge clk);
        #1;
        check(hs == 1'b1, "R9 hs rises at first edge", hs, 1);
        drain();
        settle();

        check(overlap == 0, "R10 gate overlap cycles", overlap, 0);
        check(expq.size() == 0, "R1 unmatched expectations", expq.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule